// File: doc/BRIEF.md
# ADC SPI command sequencer

This block is an SPI host that runs a delta-sigma converter entirely through single-byte opcodes. Once reset is released it halts the converter. It then writes the full bank of configuration registers in one burst and reads the bank back to confirm it. After that it starts a conversion and keeps polling the configuration byte that carries the data-ready flag until that flag clears. Each result arrives as three data bytes followed by a checksum byte.

Every result is reported with a one-cycle pulse on exactly one of three outputs. A result with a good checksum and a new value is a fresh sample. A result with a good checksum that repeats the previous value exactly is flagged as suspect. A result with a bad checksum is reported as a checksum error. After each read the sequencer waits a programmable restart interval before it starts the next conversion. A failed readback and a poll timeout are held as error levels, and both send the sequencer back to its halt-and-configure sequence.

Top module: `adc_cmd_seq`

## Requirements
- R1: After reset the first frame is the single byte 0x11 (halt), and it is sent again after every readback mismatch or poll timeout.
- R2: The configuration frame is 0x40, then the count byte NREG-1 (0x08 for nine registers), then register 0 to register NREG-1 taken from `cfg_regs[8*i+7:8*i]`.
- R3: The readback frame is 0x20, 0x08, then NREG zero bytes. Returned bytes 3 to NREG+2 are compared in order with register 0 onward. Any difference sets `cfg_err` to 1 and returns to R1. A full match clears `cfg_err` and sends the start frame, the single byte 0x08.
- R4: The poll frame is 0x22, 0x00, 0x00. Bit 7 of the third returned byte set to 1 means a conversion is still pending and another poll follows. Bit 7 at 0 means the next frame is the read frame.
- R5: When POLL_LIMIT consecutive polls after one start all return pending, `timeout_err` becomes 1 and the next frame is 0x11. A later poll that returns ready clears `timeout_err`.
- R6: The read frame is 0x12 followed by four zero bytes. Returned bytes 2 to 4 are the result, MSB first. Returned byte 5 is the checksum, equal to (b2+b3+b4+0x9B) mod 256; for example 3F E7 7F gives 0x40. The result pulse is high in the cycle that starts on the first clock edge after the edge that deasserts chip select at the end of the read frame.
- R7: A checksum mismatch pulses `crc_err`. It gives no `sample_valid`, leaves `sample_data` unchanged, and does not replace the stored previous value.
- R8: A checked result that equals the previous checked result pulses `sample_suspect` instead of `sample_valid`.
- R9: Any other checked result pulses `sample_valid`, and `sample_data` shows that value.
- R10: At least RESTART_CYCLES clocks pass between chip select rising after a read frame and chip select falling for the next start frame.
- R11: SPI timing: `spi_sclk` is low whenever `spi_cs_n` is high. `spi_mosi` changes only on the rising SCLK edge and `spi_miso` is sampled on the falling edge. Each SCLK phase lasts CLK_DIV clocks. Bytes go out MSB first. `spi_cs_n` stays low for the whole of each frame and changes only while SCLK is low.
- R12: While `rst_n` is low, `spi_cs_n`=1, `spi_sclk`=0, every result pulse and error flag is 0, and `sample_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_regs | input | NREG*8 | Register image to write, register i in bits 8i+7..8i |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Host-to-converter serial data |
| spi_miso | input | 1 | Converter-to-host serial data |
| sample_valid | output | 1 | One-cycle pulse: fresh result |
| sample_suspect | output | 1 | One-cycle pulse: result repeats the previous one |
| sample_data | output | 24 | Last result whose checksum passed |
| crc_err | output | 1 | One-cycle pulse: checksum mismatch |
| cfg_err | output | 1 | Level: last readback mismatched |
| timeout_err | output | 1 | Level: poll limit reached without data ready |

## Verification
The bench watches every frame at the pins through a bit-level converter model. At the clock edge where chip select rises it compares the whole frame and the error levels. Those levels change on that same edge, so they are sampled at the following falling clock edge. The result pulse is due exactly one clock edge after chip select deasserts at the end of a read frame, so the bench expects it at the second falling clock edge after it sees chip select high. It flags any pulse that appears at any other time. The SCLK high width is counted in clocks, and the restart gap is timed from the chip select rise after a read to the next chip select fall.

// File: rtl/adc_seq_pkg.sv
// Package: shared opcodes, sequencer state type and checksum rule for the
// ADC SPI command sequencer. Assumes single-byte opcodes with the register
// address in the low nibble of the read and write opcodes.
package adc_seq_pkg;
    localparam logic [7:0] OP_HALT   = 8'h11;
    localparam logic [7:0] OP_WRITE  = 8'h40;
    localparam logic [7:0] OP_READ   = 8'h20;
    localparam logic [7:0] OP_GO     = 8'h08;
    localparam logic [7:0] OP_RESULT = 8'h12;
    localparam logic [3:0] FLAG_REG  = 4'd2;
    localparam int         FLAG_BIT  = 7;
    localparam logic [7:0] SUM_SEED  = 8'h9B;

    typedef enum logic [2:0] {
        ST_HALT, ST_WRITE, ST_VERIFY, ST_GO, ST_POLL, ST_FETCH, ST_REST
    } seq_state_t;

    function automatic logic [7:0] result_sum(input logic [23:0] d);
        return d[23:16] + d[15:8] + d[7:0] + SUM_SEED;
    endfunction
endpackage

// File: rtl/adc_spi_byte.sv
// Module: one-byte SPI shifter. Drives MOSI on the rising SCLK edge and
// samples MISO on the falling edge, MSB first. Each SCLK phase lasts DIV
// clocks. Assumes the caller handles chip select and pulses go only while
// the shifter is idle.
module adc_spi_byte #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic          busy;
    logic          rise_next;
    logic [2:0]    bits;
    logic [DW-1:0] div_cnt;
    logic [7:0]    sh_tx;

    // Bit engine: alternates rising and falling SCLK phases for eight bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; rise_next <= 1'b0; bits <= '0; div_cnt <= '0;
            sh_tx <= '0; rx <= '0; sclk <= 1'b0; mosi <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy <= 1'b1; rise_next <= 1'b1; bits <= '0;
                    div_cnt <= '0; sh_tx <= tx;
                end
            end else if (div_cnt != '0) begin
                div_cnt <= div_cnt - 1'b1;
            end else if (rise_next) begin
                sclk <= 1'b1;
                mosi <= sh_tx[7];
                sh_tx <= {sh_tx[6:0], 1'b0};
                rise_next <= 1'b0;
                div_cnt <= DW'(DIV - 1);
            end else begin
                sclk <= 1'b0;
                rx <= {rx[6:0], miso};
                bits <= bits + 1'b1;
                if (bits == 3'd7) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    rise_next <= 1'b1;
                    div_cnt <= DW'(DIV - 1);
                end
            end
        end
    end
endmodule

// File: rtl/adc_frame_gen.sv
// Module: combinational frame builder. Returns the outgoing byte at a given
// index of the frame for the current sequencer state, plus the index of
// the frame's last byte. Assumes NREG registers starting at address 0.
module adc_frame_gen
    import adc_seq_pkg::*;
#(
    parameter int NREG = 9,
    localparam int IW  = $clog2(NREG + 3)
) (
    input  seq_state_t       state,
    input  logic [IW-1:0]    idx,
    input  logic [NREG*8-1:0] cfg,
    output logic [7:0]       tx_byte,
    output logic [IW-1:0]    last_idx
);
    localparam logic [7:0] COUNT_BYTE = 8'(NREG - 1);

    // Byte selection per frame type and position.
    always_comb begin
        tx_byte  = 8'h00;
        last_idx = '0;
        unique case (state)
            ST_HALT:  tx_byte = OP_HALT;
            ST_GO:    tx_byte = OP_GO;
            ST_WRITE: begin
                last_idx = IW'(NREG + 1);
                if (idx == '0)            tx_byte = OP_WRITE;
                else if (idx == IW'(1))   tx_byte = COUNT_BYTE;
                for (int i = 0; i < NREG; i++)
                    if (idx == IW'(i + 2)) tx_byte = cfg[8*i +: 8];
            end
            ST_VERIFY: begin
                last_idx = IW'(NREG + 1);
                if (idx == '0)            tx_byte = OP_READ;
                else if (idx == IW'(1))   tx_byte = COUNT_BYTE;
            end
            ST_POLL: begin
                last_idx = IW'(2);
                if (idx == '0) tx_byte = OP_READ | {4'h0, FLAG_REG};
            end
            ST_FETCH: begin
                last_idx = IW'(4);
                if (idx == '0) tx_byte = OP_RESULT;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/adc_result_chk.sv
// Module: result checker. Validates the checksum of a 24-bit result. On a
// good checksum it reports the result as fresh or as a repeat of the
// previous good result. Each outcome is a one-cycle pulse one clock after
// go. Assumes go is a single-cycle strobe.
module adc_result_chk
    import adc_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic [23:0] data,
    input  logic [7:0]  csum,
    output logic        fresh,
    output logic        repeat_hit,
    output logic        sum_bad,
    output logic [23:0] held
);
    logic have_prev;

    // Outcome classification and storage of the last good value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh <= 1'b0; repeat_hit <= 1'b0; sum_bad <= 1'b0;
            held <= '0; have_prev <= 1'b0;
        end else begin
            fresh <= 1'b0; repeat_hit <= 1'b0; sum_bad <= 1'b0;
            if (go) begin
                if (csum != result_sum(data)) begin
                    sum_bad <= 1'b1;
                end else begin
                    held <= data;
                    have_prev <= 1'b1;
                    if (have_prev && data == held) repeat_hit <= 1'b1;
                    else                           fresh <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_cmd_seq.sv
// Module: top of the ADC SPI command sequencer. Steps through halt, write,
// verify, start, poll and fetch frames, then rests before the next start.
// Assumes a converter that latches MOSI on falling SCLK and drives MISO
// after rising SCLK, and RESTART_CYCLES, POLL_LIMIT and GAP_CYCLES >= 1.
module adc_cmd_seq
    import adc_seq_pkg::*;
#(
    parameter int NREG           = 9,
    parameter int CLK_DIV        = 2,
    parameter int GAP_CYCLES     = 4,
    parameter int RESTART_CYCLES = 160000,
    parameter int POLL_LIMIT     = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG*8-1:0] cfg_regs,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              sample_valid,
    output logic              sample_suspect,
    output logic [23:0]       sample_data,
    output logic              crc_err,
    output logic              cfg_err,
    output logic              timeout_err
);
    localparam int IW = $clog2(NREG + 3);
    localparam int RW = $clog2(RESTART_CYCLES + 1);
    localparam int PW = $clog2(POLL_LIMIT + 1);
    localparam int GW = $clog2(GAP_CYCLES + 1);

    seq_state_t    state;
    logic          in_xfer, go, byte_done, chk_go, mism, rb_bad;
    logic [IW-1:0] idx, sel_idx, last_idx;
    logic [GW-1:0] gap_cnt;
    logic [RW-1:0] wait_cnt;
    logic [PW-1:0] poll_cnt;
    logic [7:0]    tx_q, tx_next, rx_byte, rb_exp, chk_csum;
    logic [23:0]   res_q;

    assign sel_idx = in_xfer ? idx + 1'b1 : '0;

    adc_frame_gen #(.NREG(NREG)) u_frame (
        .state(state), .idx(sel_idx), .cfg(cfg_regs),
        .tx_byte(tx_next), .last_idx(last_idx)
    );

    adc_spi_byte #(.DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .go(go), .tx(tx_q), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .done(byte_done), .rx(rx_byte)
    );

    adc_result_chk u_check (
        .clk(clk), .rst_n(rst_n), .go(chk_go), .data(res_q), .csum(chk_csum),
        .fresh(sample_valid), .repeat_hit(sample_suspect), .sum_bad(crc_err),
        .held(sample_data)
    );

    // Expected readback byte at the current index and mismatch detection.
    always_comb begin
        rb_exp = 8'h00;
        for (int i = 0; i < NREG; i++)
            if (idx == IW'(i + 2)) rb_exp = cfg_regs[8*i +: 8];
        rb_bad = (state == ST_VERIFY) && (idx >= IW'(2)) && (rx_byte != rb_exp);
    end

    // Sequencer: frame gaps, byte issue, response capture, state steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HALT; in_xfer <= 1'b0; go <= 1'b0; idx <= '0;
            gap_cnt <= '0; wait_cnt <= '0; poll_cnt <= '0; tx_q <= '0;
            spi_cs_n <= 1'b1; mism <= 1'b0; res_q <= '0; chk_go <= 1'b0;
            chk_csum <= '0; cfg_err <= 1'b0; timeout_err <= 1'b0;
        end else begin
            go <= 1'b0;
            chk_go <= 1'b0;
            if (state == ST_REST) begin
                if (wait_cnt == RW'(RESTART_CYCLES - 1)) begin
                    state <= ST_GO; wait_cnt <= '0; gap_cnt <= '0;
                end else begin
                    wait_cnt <= wait_cnt + 1'b1;
                end
            end else if (!in_xfer) begin
                if (gap_cnt == GW'(GAP_CYCLES - 1)) begin
                    gap_cnt <= '0; spi_cs_n <= 1'b0; in_xfer <= 1'b1;
                    idx <= '0; go <= 1'b1; tx_q <= tx_next; mism <= 1'b0;
                end else begin
                    gap_cnt <= gap_cnt + 1'b1;
                end
            end else if (byte_done) begin
                if (state == ST_FETCH && idx != '0 && idx != last_idx)
                    res_q <= {res_q[15:0], rx_byte};
                mism <= mism | rb_bad;
                if (idx != last_idx) begin
                    idx <= idx + 1'b1; go <= 1'b1; tx_q <= tx_next;
                end else begin
                    spi_cs_n <= 1'b1; in_xfer <= 1'b0; gap_cnt <= '0;
                    unique case (state)
                        ST_HALT:  state <= ST_WRITE;
                        ST_WRITE: state <= ST_VERIFY;
                        ST_VERIFY: begin
                            cfg_err <= mism | rb_bad;
                            state <= (mism | rb_bad) ? ST_HALT : ST_GO;
                        end
                        ST_GO: begin
                            poll_cnt <= '0; state <= ST_POLL;
                        end
                        ST_POLL: begin
                            if (!rx_byte[FLAG_BIT]) begin
                                timeout_err <= 1'b0; state <= ST_FETCH;
                            end else if (poll_cnt == PW'(POLL_LIMIT - 1)) begin
                                timeout_err <= 1'b1; state <= ST_HALT;
                            end else begin
                                poll_cnt <= poll_cnt + 1'b1;
                            end
                        end
                        ST_FETCH: begin
                            chk_go <= 1'b1; chk_csum <= rx_byte;
                            wait_cnt <= '0; state <= ST_REST;
                        end
                        default: state <= ST_HALT;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/adc_cmd_seq_chk.sv
// Module: assertion checker bound to adc_cmd_seq. Watches the SPI pins and
// the result outputs. Assumes synchronous active-low reset.
module adc_cmd_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        spi_sclk,
    input logic        spi_cs_n,
    input logic        spi_mosi,
    input logic        sample_valid,
    input logic        sample_suspect,
    input logic        crc_err,
    input logic [23:0] sample_data
);
    // R11: clock idles low while the converter is deselected.
    a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R11: outgoing data is held across the falling (latching) edge.
    a_r11_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_sclk) |-> $stable(spi_mosi));

    // R11: chip select moves only while SCLK has been low.
    a_r11_cs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_cs_n) |-> (!spi_sclk && !$past(spi_sclk)));

    // R7: at most one outcome per result.
    a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_valid, sample_suspect, crc_err}));

    // R8: a repeat leaves the reported value unchanged.
    a_r8_repeat_same: assert property (@(posedge clk) disable iff (!rst_n)
        sample_suspect |-> $stable(sample_data));

    // R9: the reported value changes only with a fresh sample.
    a_r9_data_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sample_data) |-> sample_valid);

    // R6: outcomes follow chip select rising on the previous edge.
    a_r6_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid || sample_suspect || crc_err) |->
            ($past(spi_cs_n) && !$past(spi_cs_n, 2)));
endmodule

bind adc_cmd_seq adc_cmd_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .sample_valid(sample_valid),
    .sample_suspect(sample_suspect), .crc_err(crc_err),
    .sample_data(sample_data)
);

// File: tb/adc_cmd_seq_test.sv
// Bench: bit-level converter model plus a frame monitor that predicts every
// frame, error level and result outcome from the requirements.
module adc_cmd_seq_test;
    localparam int NREG = 9, DIV = 2, GAP = 4, REST = 40, PLIM = 5;

    logic clk = 1'b0, rst_n = 1'b0, miso = 1'b0;
    logic [NREG*8-1:0] cfg;
    logic sclk, cs_n, mosi, s_valid, s_susp, c_err, g_err, t_err;
    logic [23:0] s_data;

    always #10 clk = ~clk;

    adc_cmd_seq #(.NREG(NREG), .CLK_DIV(DIV), .GAP_CYCLES(GAP),
        .RESTART_CYCLES(REST), .POLL_LIMIT(PLIM)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_regs(cfg), .spi_sclk(sclk),
        .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
        .sample_valid(s_valid), .sample_suspect(s_susp), .sample_data(s_data),
        .crc_err(c_err), .cfg_err(g_err), .timeout_err(t_err));

    int n_checks = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] base_val(input int k);
        if (k == 0) return 24'h3FE77F;
        return 24'((k * 32'h00051A37) ^ 32'h0000A5C3);
    endfunction
    function automatic logic [23:0] sample_val(input int k);
        return (k == 3 || k == 7) ? base_val(k - 1) : base_val(k);
    endfunction
    function automatic logic [7:0] csum_of(input logic [23:0] v);
        return v[23:16] + v[15:8] + v[7:0] + 8'h9B;
    endfunction

    // ---------------- converter model ----------------
    logic [7:0] rxb [0:15];
    logic [7:0] resp [0:15];
    logic [7:0] regs [0:NREG-1];
    logic [7:0] shin = 8'h00;
    int bitc = 0, bytec = 0, poll_left = 0, smp_idx = 0;
    bit never_ready = 1'b0, bad_rb_once = 1'b1;

    initial for (int i = 0; i < NREG; i++) regs[i] = 8'h00;

    always @(negedge cs_n) begin
        bitc = 0; bytec = 0;
        for (int i = 0; i < 16; i++) resp[i] = 8'h00;
    end

    always @(posedge sclk) if (!cs_n && bytec < 16) miso = resp[bytec][7-bitc];

    always @(negedge sclk) if (!cs_n) begin
        shin = {shin[6:0], mosi};
        bitc++;
        if (bitc == 8) begin
            bitc = 0;
            if (bytec < 16) rxb[bytec] = shin;
            if (bytec == 0) begin
                case (shin)
                    8'h08: poll_left = smp_idx % 4;
                    8'h22: begin
                        resp[2] = (never_ready || poll_left > 0) ? 8'h90 : 8'h10;
                        if (poll_left > 0) poll_left--;
                    end
                    8'h20: begin
                        for (int i = 0; i < NREG; i++) resp[2+i] = regs[i];
                        if (bad_rb_once) begin resp[6] ^= 8'h04; bad_rb_once = 1'b0; end
                    end
                    8'h12: begin
                        logic [23:0] v;
                        v = sample_val(smp_idx);
                        resp[1] = v[23:16]; resp[2] = v[15:8]; resp[3] = v[7:0];
                        resp[4] = csum_of(v) ^ ((smp_idx == 5 || smp_idx == 9) ? 8'hFF : 8'h00);
                        smp_idx++;
                    end
                    default: ;
                endcase
            end else if (rxb[0] == 8'h40 && bytec >= 2 && bytec < NREG + 2) begin
                regs[bytec-2] = shin;
            end
            bytec++;
        end
    end

    // ---------------- frame monitor ----------------
    // kinds: 0 halt, 1 write, 2 verify, 3 start, 4 poll, 5 fetch
    function automatic int exp_len(input int kind);
        case (kind)
            1, 2: return NREG + 2;
            4: return 3;
            5: return 5;
            default: return 1;
        endcase
    endfunction
    function automatic logic [7:0] exp_byte(input int kind, input int i);
        case (kind)
            0: return 8'h11;
            1: return (i == 0) ? 8'h40 : (i == 1) ? 8'(NREG - 1) : cfg[8*(i-2) +: 8];
            2: return (i == 0) ? 8'h20 : (i == 1) ? 8'(NREG - 1) : 8'h00;
            3: return 8'h08;
            4: return (i == 0) ? 8'h22 : 8'h00;
            default: return (i == 0) ? 8'h12 : 8'h00;
        endcase
    endfunction

    int exp_kind = 0, polls = 0, cyc = 0, read_end = 0, pcnt = 0, exp_ev = 0;
    int reads_done = 0, sclk_hi = 0, wchecks = 0;
    bit exp_cfg = 0, exp_to = 0, to_seen = 0, last_read = 0, pend = 0, have_prev = 0;
    bit prev_cs = 1'b1;
    logic [23:0] prev_val = 24'h0;

    task automatic frame_end();
        bit ok;
        int next;
        string req;
        ok = (bytec == exp_len(exp_kind));
        for (int i = 0; i < exp_len(exp_kind) && i < 16; i++)
            if (rxb[i] != exp_byte(exp_kind, i)) ok = 0;
        case (exp_kind)
            0: req = "R1 R11"; 1: req = "R2 R11"; 2: req = "R3 R11";
            3: req = "R3 R10"; 4: req = "R4"; default: req = "R6";
        endcase
        check(ok, req, "frame bytes (first byte shown)", rxb[0], exp_byte(exp_kind, 0));
        next = 0;
        case (exp_kind)
            0: next = 1;
            1: next = 2;
            2: begin
                bit bad = 0;
                for (int i = 0; i < NREG; i++) if (resp[2+i] != cfg[8*i +: 8]) bad = 1;
                exp_cfg = bad;
                next = bad ? 0 : 3;
            end
            3: begin next = 4; polls = 0; end
            4: begin
                polls++;
                if (!resp[2][7]) begin exp_to = 0; next = 5; end
                else if (polls == PLIM) begin exp_to = 1; next = 0; to_seen = 1; end
                else next = 4;
            end
            default: begin
                logic [23:0] v;
                v = {resp[1], resp[2], resp[3]};
                if (resp[4] != csum_of(v)) exp_ev = 3;
                else begin
                    exp_ev = (have_prev && v == prev_val) ? 2 : 1;
                    have_prev = 1; prev_val = v;
                end
                pend = 1; pcnt = 0; last_read = 1; read_end = cyc; reads_done++;
                next = 3;
            end
        endcase
        check(g_err == exp_cfg, "R3", "cfg_err after frame", g_err, exp_cfg);
        check(t_err == exp_to, "R5", "timeout_err after frame", t_err, exp_to);
        exp_kind = next;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (pend) pcnt++;
            if (pend && pcnt == 1) begin
                check(s_valid == (exp_ev == 1), "R9", "sample_valid", s_valid, exp_ev == 1);
                check(s_susp == (exp_ev == 2), "R8", "sample_suspect", s_susp, exp_ev == 2);
                check(c_err == (exp_ev == 3), "R7", "crc_err", c_err, exp_ev == 3);
                check(s_data == prev_val, "R7 R9", "sample_data", s_data, prev_val);
                pend = 0;
            end else if (s_valid || s_susp || c_err) begin
                check(0, "R6", "result pulse out of place", 1, 0);
            end
            if (prev_cs && !cs_n && last_read) begin
                check(cyc - read_end >= REST, "R10", "restart gap", cyc - read_end, REST);
                last_read = 0;
            end
            if (!prev_cs && cs_n) frame_end();
            if (sclk) sclk_hi++;
            else if (sclk_hi > 0) begin
                if (wchecks < 8) check(sclk_hi == DIV, "R11", "sclk high width", sclk_hi, DIV);
                wchecks++;
                sclk_hi = 0;
            end
        end
        prev_cs = cs_n;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) cfg[8*i +: 8] = 8'(8'h05 + 8'h11 * i);
        repeat (5) @(negedge clk);
        check(cs_n == 1'b1, "R12", "cs_n in reset", cs_n, 1);
        check(sclk == 1'b0, "R12", "sclk in reset", sclk, 0);
        check({s_valid, s_susp, c_err, g_err, t_err} == 5'b0, "R12", "flags in reset",
              {s_valid, s_susp, c_err, g_err, t_err}, 0);
        check(s_data == 24'h0, "R12", "sample_data in reset", s_data, 0);
        rst_n = 1'b1;
        wait (reads_done >= 12);
        never_ready = 1'b1;
        wait (to_seen);
        check(t_err == 1'b1, "R5", "timeout level held", t_err, 1);
        never_ready = 1'b0;
        wait (reads_done >= 15);
        repeat (20) @(negedge clk);
        check(t_err == 1'b0, "R5", "timeout cleared by ready poll", t_err, 0);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R1 watchdog expired: actual running expected done");
        summary();
    end
endmodule